// File: doc/BRIEF.md
# Coordinate-Triggered Pixel Drawing Engine

This block sits between a slow host processor and a synchronous frame-buffer memory that holds a 1920 by 1080 picture, one 18-bit word per pixel. The host sets up an operation through a small write-only register file: operation code, foreground and background colors, rectangle extent, eight glyph rows and the two coordinates. The horizontal coordinate must be written first. Writing the vertical coordinate launches the selected operation at once.

Four operations exist. Plot writes one pixel. Readback fetches one pixel and leaves it in a read-only result output. Fill paints a solid rectangle. Character paints an 8x8 glyph, using two colors. While an operation runs, the engine raises a wait line that stalls the host. Register writes that arrive during that time are dropped.

The memory side is a pipelined synchronous-SRAM port with a fixed two-cycle read latency. It has no handshake: the memory accepts a request on every clock and never pushes back. The host side is a plain write strobe, and the wait line is its only form of back-pressure.

Top module: `pixel_gfx_engine`

## Requirements
- R1: Register addresses are 0 operation (0 plot, 1 readback, 2 fill, 3 character), 1 foreground, 2 background, 3 width, 4 height, 5 X, 6 Y, and 8+r for glyph row r (low 8 bits). Only a write to address 6 while idle launches an operation; writes to other addresses never raise `host_wait`.
- R2: `host_wait` is high from the cycle after the launching write until the operation ends, and is low at reset. Every register write made while `host_wait` is high is ignored, including a write to Y.
- R3: A pixel (x,y) lives at memory word y*1920 + x.
- R4: Plot writes the foreground color to (X,Y) and holds `host_wait` for exactly 1 cycle.
- R5: Readback issues one read of (X,Y). It captures `mem_rdata` two clocks after the request into `rd_color` and holds `host_wait` for 3 cycles. `rd_color` changes only at the end of a readback and is 0 after reset.
- R6: Fill writes the foreground color to every (X+i, Y+j) with i < width and j < height. It writes one pixel per clock, with i varying fastest, so `host_wait` lasts width*height cycles. A zero width or height writes nothing and lasts 1 cycle.
- R7: Character visits the 8x8 cell in row-major order, one pixel per clock, and holds `host_wait` for 64 cycles. Bit 7-c of row r colors (X+c, Y+r). A 1 bit gives the foreground color and a 0 bit gives the background color.
- R8: A pixel with x > 1919 or y > 1079 is never accessed: no write, and no read request. A readback of such a pixel returns 0. The skipped pixel still takes its clock.
- R9: The memory port is idle (`mem_en` low) whenever `host_wait` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_we | input | 1 | Register write strobe |
| host_addr | input | 4 | Register address |
| host_wdata | input | 18 | Register write data |
| host_wait | output | 1 | Stall to host while an operation runs |
| rd_color | output | 18 | Read-only readback result |
| mem_en | output | 1 | Memory request this cycle |
| mem_we | output | 1 | Request is a write (1) or read (0) |
| mem_addr | output | 21 | Linear pixel address |
| mem_wdata | output | 18 | Write color |
| mem_rdata | input | 18 | Read data, valid two clocks after the request |

## Verification
The assertions assume that the memory returns read data exactly two clocks after a request and never stalls. They also assume that the operation code does not change between the launching write and the end of the run. The second assumption holds because the engine drops host writes while busy. The bench memory model returns data with exactly that two-clock latency, and the stimulus writes registers either while idle or deliberately during a run, to test that such writes are dropped. Coordinates are chosen at the frame edges and beyond them, so clipped pixels and clipped readbacks are both exercised.

// File: rtl/gfx_pkg.sv
package gfx_pkg;
  typedef enum logic [1:0] {OP_PLOT = 2'd0, OP_READ = 2'd1, OP_FILL = 2'd2, OP_CHAR = 2'd3} op_e;
  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_RD1, ST_RD2} st_e;
  localparam logic [3:0] RA_OP  = 4'd0;
  localparam logic [3:0] RA_FG  = 4'd1;
  localparam logic [3:0] RA_BG  = 4'd2;
  localparam logic [3:0] RA_WID = 4'd3;
  localparam logic [3:0] RA_HGT = 4'd4;
  localparam logic [3:0] RA_X   = 4'd5;
  localparam logic [3:0] RA_Y   = 4'd6;
  localparam int GLYPH_DIM = 8;
endpackage

// File: rtl/gfx_regs.sv
module gfx_regs
  import gfx_pkg::*;
#(
  parameter int CW   = 18,
  parameter int CRDW = 11
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr_en,
  input  logic [3:0]                    wr_addr,
  input  logic [CW-1:0]                 wr_data,
  output op_e                           op,
  output logic [CW-1:0]                 fg,
  output logic [CW-1:0]                 bg,
  output logic [CRDW-1:0]               wid,
  output logic [CRDW-1:0]               hgt,
  output logic [CRDW-1:0]               px,
  output logic [CRDW-1:0]               py,
  output logic [GLYPH_DIM*GLYPH_DIM-1:0] glyph,
  output logic                          launch
);
  assign launch = wr_en && (wr_addr == RA_Y);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      op    <= OP_PLOT;
      fg    <= '0;
      bg    <= '0;
      wid   <= '0;
      hgt   <= '0;
      px    <= '0;
      py    <= '0;
      glyph <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        RA_OP:   op  <= op_e'(wr_data[1:0]);
        RA_FG:   fg  <= wr_data;
        RA_BG:   bg  <= wr_data;
        RA_WID:  wid <= wr_data[CRDW-1:0];
        RA_HGT:  hgt <= wr_data[CRDW-1:0];
        RA_X:    px  <= wr_data[CRDW-1:0];
        RA_Y:    py  <= wr_data[CRDW-1:0];
        default: if (wr_addr[3]) glyph[wr_addr[2:0]*GLYPH_DIM +: GLYPH_DIM] <= wr_data[GLYPH_DIM-1:0];
      endcase
    end
  end
endmodule

// File: rtl/gfx_walk.sv
module gfx_walk
  import gfx_pkg::*;
#(
  parameter int CRDW = 11
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            launch,
  input  op_e             op,
  input  logic [CRDW-1:0] wid,
  input  logic [CRDW-1:0] hgt,
  output logic            busy,
  output logic            run,
  output logic            capture,
  output logic            empty,
  output logic [CRDW-1:0] cx,
  output logic [CRDW-1:0] cy
);
  st_e             st;
  logic [CRDW-1:0] lim_w, lim_h;
  logic            last;

  assign lim_w   = (op == OP_CHAR) ? CRDW'(GLYPH_DIM) : wid;
  assign lim_h   = (op == OP_CHAR) ? CRDW'(GLYPH_DIM) : hgt;
  assign empty   = (op == OP_FILL) && (wid == '0 || hgt == '0);
  assign last    = (op == OP_PLOT) || empty || (cx == lim_w - 1'b1 && cy == lim_h - 1'b1);
  assign busy    = (st != ST_IDLE);
  assign run     = (st == ST_RUN);
  assign capture = (st == ST_RD2);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= ST_IDLE;
      cx <= '0;
      cy <= '0;
    end else begin
      case (st)
        ST_IDLE: if (launch) begin
          st <= ST_RUN;
          cx <= '0;
          cy <= '0;
        end
        ST_RUN: begin
          if (op == OP_READ)            st <= ST_RD1;
          else if (last)                st <= ST_IDLE;
          else if (cx == lim_w - 1'b1) begin
            cx <= '0;
            cy <= cy + 1'b1;
          end else                      cx <= cx + 1'b1;
        end
        ST_RD1:  st <= ST_RD2;
        default: st <= ST_IDLE;
      endcase
    end
  end

  p_launch_waits_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (launch && !busy) |=> busy);
  p_plot_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (launch && !busy && op == OP_PLOT) |=> busy ##1 !busy);
  p_read_three_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (launch && !busy && op == OP_READ) |=> busy ##1 busy ##1 busy ##1 !busy);
endmodule

// File: rtl/gfx_addr.sv
module gfx_addr #(
  parameter int HRES = 1920,
  parameter int VRES = 1080,
  parameter int CRDW = 11,
  parameter int AW   = 21
) (
  input  logic [CRDW:0]   x,
  input  logic [CRDW:0]   y,
  output logic            inb,
  output logic [AW-1:0]   addr
);
  assign inb = (x < (CRDW+1)'(HRES)) && (y < (CRDW+1)'(VRES));

  generate
    if (HRES == 1920) begin : g_shift
      assign addr = (AW'(y) << 11) - (AW'(y) << 7) + AW'(x);
    end else begin : g_mul
      assign addr = AW'(y) * AW'(HRES) + AW'(x);
    end
  endgenerate
endmodule

// File: rtl/pixel_gfx_engine.sv
module pixel_gfx_engine
  import gfx_pkg::*;
#(
  parameter int HRES = 1920,
  parameter int VRES = 1080,
  parameter int CW   = 18,
  parameter int AW   = 21,
  parameter int CRDW = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          host_we,
  input  logic [3:0]    host_addr,
  input  logic [CW-1:0] host_wdata,
  output logic          host_wait,
  output logic [CW-1:0] rd_color,
  output logic          mem_en,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [CW-1:0] mem_wdata,
  input  logic [CW-1:0] mem_rdata
);
  localparam int NPIX = HRES * VRES;

  op_e                            op;
  logic [CW-1:0]                  fg, bg;
  logic [CRDW-1:0]                wid, hgt, px, py, cx, cy;
  logic [GLYPH_DIM*GLYPH_DIM-1:0] glyph;
  logic                           launch, busy, run, capture, empty, inb, rd_ok;
  logic [CRDW:0]                  sx, sy;
  logic [5:0]                     gidx;

  gfx_regs #(.CW(CW), .CRDW(CRDW)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(host_we && !busy), .wr_addr(host_addr),
    .wr_data(host_wdata), .op(op), .fg(fg), .bg(bg), .wid(wid), .hgt(hgt),
    .px(px), .py(py), .glyph(glyph), .launch(launch)
  );

  gfx_walk #(.CRDW(CRDW)) u_walk (
    .clk(clk), .rst_n(rst_n), .launch(launch), .op(op), .wid(wid), .hgt(hgt),
    .busy(busy), .run(run), .capture(capture), .empty(empty), .cx(cx), .cy(cy)
  );

  assign sx = (CRDW+1)'(px) + (CRDW+1)'(cx);
  assign sy = (CRDW+1)'(py) + (CRDW+1)'(cy);

  gfx_addr #(.HRES(HRES), .VRES(VRES), .CRDW(CRDW), .AW(AW)) u_addr (
    .x(sx), .y(sy), .inb(inb), .addr(mem_addr)
  );

  assign gidx      = {cy[2:0], ~cx[2:0]};
  assign mem_wdata = (op == OP_CHAR) ? (glyph[gidx] ? fg : bg) : fg;
  assign mem_en    = run && inb && !empty;
  assign mem_we    = (op != OP_READ);
  assign host_wait = busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_ok    <= 1'b0;
      rd_color <= '0;
    end else begin
      if (run && op == OP_READ) rd_ok <= inb;
      if (capture) rd_color <= rd_ok ? mem_rdata : '0;
    end
  end

  p_mem_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !host_wait |-> !mem_en);
  p_addr_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_en |-> (mem_addr < AW'(NPIX)));
  p_result_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!host_wait && $past(!host_wait)) |-> $stable(rd_color));
  p_busy_writes_dropped_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wait && host_we) |=> ($stable(px) && $stable(py) && $stable(op)));
endmodule

// File: tb/pixel_gfx_engine_test.sv
module pixel_gfx_engine_test;
  localparam int CLK_PERIOD = 10;
  localparam int HR = 1920;
  localparam int VR = 1080;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_we = 1'b0;
  logic [3:0]  host_addr = '0;
  logic [17:0] host_wdata = '0;
  logic        host_wait, mem_en, mem_we;
  logic [17:0] rd_color, mem_wdata, mem_rdata;
  logic [20:0] mem_addr;

  int total = 0;
  int bad = 0;
  int cyc = 0;

  pixel_gfx_engine uut (
    .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_wait(host_wait), .rd_color(rd_color),
    .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // frame memory model: two-clock read latency
  logic [17:0] fb [int];
  logic [17:0] pipe1 = '0;
  logic [17:0] rdat = '0;
  assign mem_rdata = rdat;
  always @(posedge clk) begin
    if (mem_en) begin
      if (mem_we) fb[int'(mem_addr)] = mem_wdata;
      else pipe1 <= fb.exists(int'(mem_addr)) ? fb[int'(mem_addr)] : 18'd0;
    end
    rdat <= pipe1;
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // reference model state
  int m_op, m_fg, m_bg, m_w, m_h, m_x, m_y;
  int m_gl [8];
  int busy_cnt = 0;
  int wq_a [$];
  int wq_d [$];
  int exp_rd = 0;
  int rd_addr = 0;
  bit rd_pend = 0;

  function automatic bit inside_frame(int x, int y);
    return (x < HR) && (y < VR);
  endfunction

  task automatic push_px(int x, int y, int c);
    if (inside_frame(x, y)) begin
      wq_a.push_back(y * HR + x);
      wq_d.push_back(c);
    end
  endtask

  task automatic model_launch();
    case (m_op)
      0: begin busy_cnt = 1; push_px(m_x, m_y, m_fg); end
      1: begin
        busy_cnt = 3;
        if (inside_frame(m_x, m_y)) begin
          rd_pend = 1; rd_addr = m_y * HR + m_x;
          exp_rd = fb.exists(rd_addr) ? int'(fb[rd_addr]) : 0;
        end else exp_rd = 0;
      end
      2: begin
        busy_cnt = (m_w == 0 || m_h == 0) ? 1 : m_w * m_h;
        for (int j = 0; j < m_h; j++)
          for (int i = 0; i < m_w; i++) push_px(m_x + i, m_y + j, m_fg);
      end
      default: begin
        busy_cnt = 64;
        for (int r = 0; r < 8; r++)
          for (int c = 0; c < 8; c++)
            push_px(m_x + c, m_y + r, ((m_gl[r] >> (7 - c)) & 1) ? m_fg : m_bg);
      end
    endcase
  endtask

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      busy_cnt = 0;
      m_op = 0; m_fg = 0; m_bg = 0; m_w = 0; m_h = 0; m_x = 0; m_y = 0;
      for (int r = 0; r < 8; r++) m_gl[r] = 0;
    end else if (busy_cnt > 0) busy_cnt--;
    else if (host_we) begin
      case (host_addr)
        4'd0: m_op = int'(host_wdata) & 3;
        4'd1: m_fg = int'(host_wdata);
        4'd2: m_bg = int'(host_wdata);
        4'd3: m_w = int'(host_wdata) & 'h7ff;
        4'd4: m_h = int'(host_wdata) & 'h7ff;
        4'd5: m_x = int'(host_wdata) & 'h7ff;
        4'd6: begin m_y = int'(host_wdata) & 'h7ff; model_launch(); end
        default: if (host_addr[3]) m_gl[host_addr[2:0]] = int'(host_wdata) & 'hff;
      endcase
    end
  end

  // per-clock comparison
  always @(negedge clk) begin
    if (rst_n) begin
      chk(host_wait == (busy_cnt > 0), "R2 wait window", host_wait, busy_cnt > 0);
      if (!host_wait) chk(!mem_en, "R9 port idle", mem_en, 0);
      if (mem_en && mem_we) begin
        if (wq_a.size() == 0) chk(0, "R8 unexpected write", mem_addr, 0);
        else begin
          int a, d;
          a = wq_a.pop_front();
          d = wq_d.pop_front();
          chk(int'(mem_addr) == a, "R3 write address", mem_addr, a);
          chk(int'(mem_wdata) == d, m_op == 3 ? "R7 glyph color" : "R6 R4 color", mem_wdata, d);
        end
      end
      if (mem_en && !mem_we) begin
        chk(rd_pend && int'(mem_addr) == rd_addr, "R5 read request", mem_addr, rd_addr);
        rd_pend = 0;
      end
    end
  end

  always @(posedge clk) begin
    if (cyc > 150000) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic wr(input int a, input int d);
    host_we = 1'b1; host_addr = 4'(a); host_wdata = 18'(d);
    @(negedge clk);
    host_we = 1'b0;
  endtask

  task automatic wait_idle();
    while (host_wait) @(negedge clk);
    chk(wq_a.size() == 0, "R8 all writes seen", wq_a.size(), 0);
    chk(!rd_pend, "R5 R8 read issued", rd_pend, 0);
  endtask

  task automatic go(input int op, input int x, input int y);
    wr(0, op); wr(5, x); wr(6, y);
    wait_idle();
  endtask

  task automatic readback(input int x, input int y, input int expv, input string tag);
    go(1, x, y);
    chk(int'(rd_color) == expv, tag, rd_color, expv);
    chk(int'(rd_color) == exp_rd, "R5 model readback", rd_color, exp_rd);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!host_wait, "R2 reset wait", host_wait, 0);
    chk(!mem_en, "R9 reset port", mem_en, 0);
    chk(rd_color == 0, "R5 reset result", rd_color, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: non-Y writes do not launch
    wr(5, 40);
    chk(!host_wait, "R1 X write no launch", host_wait, 0);
    wr(0, 0);
    chk(!host_wait, "R1 op write no launch", host_wait, 0);

    // R4 / R3 plots
    wr(1, 'h2AAAA);
    go(0, 5, 7);
    go(0, 1919, 1079);
    wr(1, 'h15555);
    go(0, 1920, 3);     // R8 clipped
    go(0, 0, 1080);     // R8 clipped

    // R5 readback
    readback(5, 7, 'h2AAAA, "R5 readback plot");
    readback(1919, 1079, 'h2AAAA, "R5 readback corner");
    readback(2000, 0, 0, "R8 readback clipped");
    readback(6, 7, 0, "R5 readback blank");

    // R6 fill
    wr(1, 'h0F0F0); wr(3, 3); wr(4, 2);
    go(2, 10, 20);
    readback(12, 21, 'h0F0F0, "R6 fill corner");
    wr(3, 0);
    go(2, 30, 30);      // R6 zero width
    wr(3, 4); wr(4, 0);
    go(2, 30, 30);      // R6 zero height
    wr(3, 4); wr(4, 3);
    go(2, 1918, 1078);  // R8 clipped fill

    // R7 character
    wr(1, 'h3FFFF); wr(2, 'h00011);
    for (int r = 0; r < 8; r++) wr(8 + r, (r * 37 + 'h81) & 'hff);
    go(3, 100, 200);
    readback(100, 200, 'h3FFFF, "R7 glyph msb left");
    readback(101, 200, 'h00011, "R7 glyph zero bit");
    go(3, 1915, 1075);  // R8 clipped glyph

    // R2: writes during a run are dropped
    wr(1, 'h12345); wr(3, 5); wr(4, 2);
    wr(0, 2); wr(5, 300); wr(6, 300);
    wr(5, 999);
    wr(6, 50);
    wait_idle();
    wr(0, 0); wr(6, 301);
    wait_idle();
    readback(300, 301, 'h12345, "R2 X kept during run");

    repeat (3) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule